// File: doc/BRIEF.md
# Skewed int8 Systolic MAC Array

An N×N grid of integer multiply-accumulate elements for matrix-vector streaming. Each element holds one signed 8-bit weight that stays in place during a run. Activation vectors enter at the left edge of each row and shift one column per array step. Partial sums move down the columns, and each element adds its own product on the way. For activation vector k, column j of the result is the sum over i of x_k[i]·W[i][j], held in 32-bit signed arithmetic.

A run is started with a length K. The activation at each row edge is skewed by the row index, so element (i,j) meets vector k on step k+i+j. The block sequences the run itself. The `adv` output tells the feeder when the current row-edge values are consumed. After every U steps the whole array pauses for one cycle. This models the element's loop overhead and keeps the wavefront intact. Column outputs are de-skewed, so each result vector appears whole with a one-cycle valid pulse.

Two counters show how well the array is used. One counts element-MACs and the other counts steps in which any element is active. From these the sustained per-mille figure can be computed: macs·1000 / (N²·steps), then scaled by U/(U+1).

Top module: `sysarr_mac`

## Requirements
- R1: With `busy` low, a cycle with `w_we` high writes `w_data` into the element at row `w_row`, column `w_col`. With `busy` high, `w_we` has no effect on any weight.
- R2: For a run of length K ≥ 1, `res_valid` pulses exactly K times, and vectors arrive in the order k = 0..K-1. Bits [32j+31:32j] of `res_data` carry the signed 32-bit value Σ_i x_k[i]·W[i][j].
- R3: Row i of `act_in` is bits [8i+7:8i]. It is consumed only in cycles with `adv` high. On the t-th such step (t from 0) it must carry x_{t-i}[i] when i ≤ t < i+K. Values on other steps have no effect on results.
- R4: Element (i,j) performs a MAC exactly on the steps t with i+j ≤ t < i+j+K. A run therefore has S = K+2N-2 steps, and `adv` is never high while `busy` is low.
- R5: After every U steps of a run, one cycle follows with `adv` low while `busy` stays high. No bubble follows the final step. The run lasts S + floor((S-1)/U) cycles after the start edge.
- R6: `done` is high for exactly one cycle: the cycle after the edge of the final step. `busy` falls at that same edge, and the last `res_valid` pulse falls in the same cycle as `done`.
- R7: `mac_cnt` is cleared when a run starts and adds the number of active elements on every step. At `done` it equals N·N·K, and it holds until the next start.
- R8: `wall_cnt` is cleared when a run starts and counts steps with at least one active element. At `done` it equals K+2N-2.
- R9: A `start` pulse while `busy` is high is ignored. The run length, timing, counters and results of the current run are unchanged.
- R10: After reset, `busy`, `done`, `res_valid`, `adv`, `mac_cnt` and `wall_cnt` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| w_we | input | 1 | Weight write strobe |
| w_row | input | $clog2(N) | Row of the element to write |
| w_col | input | $clog2(N) | Column of the element to write |
| w_data | input | 8 | Signed weight value |
| start | input | 1 | Begin a run when idle |
| run_len | input | KW | Number of activation vectors K (≥ 1), sampled at start |
| act_in | input | 8·N | Skewed activations, row i in bits [8i+7:8i] |
| adv | output | 1 | Array steps this cycle; row-edge inputs are consumed |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| res_valid | output | 1 | `res_data` holds a new result vector |
| res_data | output | 32·N | De-skewed result, column j in bits [32j+31:32j] |
| mac_cnt | output | CW | Element-MAC count of the current or last run |
| wall_cnt | output | CW | Active-step count of the current or last run |

## Verification
A wrong weight, a lost activation tag, or a psum slipping by one step shows up in the first result vector that uses the affected element. That vector leaves the array 2N-2 steps after the run starts. A mis-timed bubble or a broken step counter shifts the `done` cycle and `wall_cnt` in the same run. A miscounted activity window makes `mac_cnt` differ from N·N·K at `done`. Ignored stimuli, such as a weight write or a restart during a run, are checked in the result values and counters of that same run.

// File: rtl/sysarr_pkg.sv
package sysarr_pkg;
  typedef logic signed [7:0]  op_t;
  typedef logic signed [31:0] acc_t;

  // one element update: add the product only when the activation tag is set
  function automatic acc_t mac_step(acc_t p, op_t a, op_t w, logic en);
    acc_t prod;
    prod = acc_t'(a) * acc_t'(w);
    return en ? p + prod : p;
  endfunction

  // number of array steps in a run of k vectors on an n x n grid
  function automatic int unsigned run_steps(int unsigned k, int unsigned n);
    return k + 2 * n - 2;
  endfunction

  // total busy cycles once bubbles are inserted after every u steps
  function automatic int unsigned busy_cycles(int unsigned s, int unsigned u);
    return s + (s - 1) / u;
  endfunction
endpackage

// File: rtl/sysarr_pe.sv
module sysarr_pe
  import sysarr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  logic w_wr,
  input  op_t  w_data,
  input  op_t  a_in,
  input  logic a_tag,
  input  acc_t p_in,
  output acc_t p_out,
  output op_t  w_q,
  output logic active
);
  assign active = adv & a_tag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q   <= '0;
      p_out <= '0;
    end else begin
      if (w_wr) w_q <= w_data;
      if (adv)  p_out <= mac_step(p_in, a_in, w_q, a_tag);
    end
  end
endmodule

// File: rtl/sysarr_seq.sv
module sysarr_seq
  import sysarr_pkg::*;
#(
  parameter int N  = 4,
  parameter int U  = 16,
  parameter int KW = 8,
  localparam int TW = KW + $clog2(2 * N) + 1,
  localparam int UW = $clog2(U + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [KW-1:0] run_len,
  output logic          busy,
  output logic          adv,
  output logic          done,
  output logic          emit,
  output logic [N-1:0]  row_tag,
  output logic [KW-1:0] k_lat
);
  logic [TW-1:0] step;
  logic [UW-1:0] ucnt;
  logic          bubble;
  logic          last;

  assign bubble = busy && (ucnt == UW'(U));
  assign adv    = busy && !bubble;
  assign last   = adv && (step == TW'(run_steps(k_lat, N) - 1));
  assign emit   = adv && (step >= TW'(2 * N - 2));

  for (genvar i = 0; i < N; i++) begin : g_tag
    assign row_tag[i] = busy && (step >= TW'(i)) && (step < TW'(i) + TW'(k_lat));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      done  <= 1'b0;
      step  <= '0;
      ucnt  <= '0;
      k_lat <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        step  <= '0;
        ucnt  <= '0;
        k_lat <= run_len;
      end else if (adv) begin
        step <= step + 1'b1;
        ucnt <= ucnt + 1'b1;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (bubble) begin
        ucnt <= '0;
      end
    end
  end
endmodule

// File: rtl/sysarr_deskew.sv
module sysarr_deskew
  import sysarr_pkg::*;
#(
  parameter int N = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv,
  input  acc_t bot [N],
  output acc_t res [N]
);
  for (genvar j = 0; j < N; j++) begin : g_col
    localparam int D = N - 1 - j;
    if (D == 0) begin : g_pass
      assign res[j] = bot[j];
    end else begin : g_dly
      acc_t sh [D];
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int k = 0; k < D; k++) sh[k] <= '0;
        end else if (adv) begin
          sh[0] <= bot[j];
          for (int k = 1; k < D; k++) sh[k] <= sh[k-1];
        end
      end
      assign res[j] = sh[D-1];
    end
  end
endmodule

// File: rtl/sysarr_mac.sv
module sysarr_mac
  import sysarr_pkg::*;
#(
  parameter int N  = 4,
  parameter int U  = 16,
  parameter int KW = 8,
  parameter int CW = 32,
  localparam int RW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            w_we,
  input  logic [RW-1:0]   w_row,
  input  logic [RW-1:0]   w_col,
  input  logic [7:0]      w_data,
  input  logic            start,
  input  logic [KW-1:0]   run_len,
  input  logic [8*N-1:0]  act_in,
  output logic            adv,
  output logic            busy,
  output logic            done,
  output logic            res_valid,
  output logic [32*N-1:0] res_data,
  output logic [CW-1:0]   mac_cnt,
  output logic [CW-1:0]   wall_cnt
);
  logic [N-1:0]     row_tag;
  logic [KW-1:0]    k_lat;
  logic             emit;
  logic [N*N-1:0]   act_flags;
  logic [8*N*N-1:0] w_flat;

  op_t  a_e [N];
  op_t  a_s [N][N-1];
  logic v_s [N][N-1];
  acc_t p_v [N][N];
  acc_t bot [N];
  acc_t res [N];

  sysarr_seq #(.N(N), .U(U), .KW(KW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .run_len(run_len),
    .busy(busy), .adv(adv), .done(done), .emit(emit),
    .row_tag(row_tag), .k_lat(k_lat)
  );

  // row-edge split and activation skew registers (advance with the array)
  for (genvar i = 0; i < N; i++) begin : g_edge
    assign a_e[i] = op_t'(act_in[8*i +: 8]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N - 1; j++) begin
          a_s[i][j] <= '0;
          v_s[i][j] <= 1'b0;
        end
    end else if (adv) begin
      for (int i = 0; i < N; i++) begin
        a_s[i][0] <= a_e[i];
        v_s[i][0] <= row_tag[i];
        for (int j = 1; j < N - 1; j++) begin
          a_s[i][j] <= a_s[i][j-1];
          v_s[i][j] <= v_s[i][j-1];
        end
      end
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_pe
      op_t  a_in;
      logic a_tag;
      acc_t p_in;
      op_t  w_q;
      logic w_wr;
      if (j == 0) begin : g_first
        assign a_in  = a_e[i];
        assign a_tag = row_tag[i];
      end else begin : g_inner
        assign a_in  = a_s[i][j-1];
        assign a_tag = v_s[i][j-1];
      end
      if (i == 0) begin : g_top
        assign p_in = '0;
      end else begin : g_below
        assign p_in = p_v[i-1][j];
      end
      assign w_wr = w_we && !busy && (w_row == RW'(i)) && (w_col == RW'(j));
      sysarr_pe u_pe (
        .clk(clk), .rst_n(rst_n), .adv(adv), .w_wr(w_wr),
        .w_data(op_t'(w_data)), .a_in(a_in), .a_tag(a_tag), .p_in(p_in),
        .p_out(p_v[i][j]), .w_q(w_q), .active(act_flags[i*N+j])
      );
      assign w_flat[8*(i*N+j) +: 8] = w_q;
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_bot
    assign bot[j] = p_v[N-1][j];
    assign res_data[32*j +: 32] = res[j];
  end

  sysarr_deskew #(.N(N)) u_dsk (
    .clk(clk), .rst_n(rst_n), .adv(adv), .bot(bot), .res(res)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      mac_cnt   <= '0;
      wall_cnt  <= '0;
    end else begin
      res_valid <= emit;
      if (start && !busy) begin
        mac_cnt  <= '0;
        wall_cnt <= '0;
      end else if (adv) begin
        mac_cnt <= mac_cnt + CW'($countones(act_flags));
        if (|act_flags) wall_cnt <= wall_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sysarr_chk.sv
module sysarr_chk
  import sysarr_pkg::*;
#(
  parameter int N  = 4,
  parameter int U  = 16,
  parameter int KW = 8,
  parameter int CW = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             adv,
  input logic             done,
  input logic             res_valid,
  input logic [KW-1:0]    k_lat,
  input logic [CW-1:0]    mac_cnt,
  input logic [CW-1:0]    wall_cnt,
  input logic [8*N*N-1:0] w_flat
);
  logic [31:0] burst;
  logic [31:0] bcyc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      burst <= '0;
      bcyc  <= '0;
    end else begin
      if (!busy)    burst <= '0;
      else if (adv) burst <= burst + 1;
      else          burst <= '0;
      if (start && !busy) bcyc <= '0;
      else if (busy)      bcyc <= bcyc + 1;
    end
  end

  AST_NO_ADV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !adv); // R4
  AST_ADV_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    adv |-> burst < 32'(U)); // R5
  AST_RUN_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> bcyc == 32'(busy_cycles(run_steps(k_lat, N), U))); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && $past(busy)); // R6
  AST_MAC_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> mac_cnt == CW'(N * N * int'(k_lat))); // R7
  AST_WALL_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> wall_cnt == CW'(run_steps(k_lat, N))); // R8
  AST_W_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(w_flat)); // R1
  AST_RESULT_ON_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> $past(adv)); // R2
  AST_LEN_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(k_lat)); // R9
endmodule

bind sysarr_mac sysarr_chk #(.N(N), .U(U), .KW(KW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .adv(adv),
  .done(done), .res_valid(res_valid), .k_lat(k_lat), .mac_cnt(mac_cnt),
  .wall_cnt(wall_cnt), .w_flat(w_flat)
);

// File: tb/sysarr_mac_bench.sv
module sysarr_mac_bench;
  localparam int N  = 4;
  localparam int U  = 3;
  localparam int KW = 8;
  localparam int CW = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            w_we = 1'b0;
  logic [1:0]      w_row = '0;
  logic [1:0]      w_col = '0;
  logic [7:0]      w_data = '0;
  logic            start = 1'b0;
  logic [KW-1:0]   run_len = '0;
  logic [8*N-1:0]  act_in = '0;
  logic            adv, busy, done, res_valid;
  logic [32*N-1:0] res_data;
  logic [CW-1:0]   mac_cnt, wall_cnt;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  logic signed [7:0] wm [N][N];
  logic signed [7:0] xm [16][N];

  always #10 clk = ~clk;

  sysarr_mac #(.N(N), .U(U), .KW(KW), .CW(CW)) u_sysarr_mac (
    .clk(clk), .rst_n(rst_n), .w_we(w_we), .w_row(w_row), .w_col(w_col),
    .w_data(w_data), .start(start), .run_len(run_len), .act_in(act_in),
    .adv(adv), .busy(busy), .done(done), .res_valid(res_valid),
    .res_data(res_data), .mac_cnt(mac_cnt), .wall_cnt(wall_cnt)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive_step(input int t, input int k_len);
    for (int i = 0; i < N; i++) begin
      int k = t - i;
      if (k >= 0 && k < k_len) act_in[8*i +: 8] = xm[k][i];
      else                     act_in[8*i +: 8] = 8'h7F; // ignored (R3)
    end
  endtask

  task automatic load_all;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        @(negedge clk);
        w_we = 1'b1; w_row = 2'(i); w_col = 2'(j); w_data = wm[i][j];
        @(posedge clk);
      end
    @(negedge clk);
    w_we = 1'b0;
  endtask

  // one run; spoil=1 attempts a weight write and a restart mid-run (R1, R9)
  task automatic run_k(input int k_len, input bit spoil, input string tag);
    int t = 0, n = 0, idx = 0, steps = 0, s, b;
    bit adv_s;
    s = k_len + 2 * N - 2;
    b = s + (s - 1) / U;
    @(negedge clk);
    drive_step(0, k_len);
    run_len = KW'(k_len);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    forever begin
      adv_s = adv;
      if (adv_s) steps++;
      @(posedge clk);
      n++;
      @(negedge clk);
      if (spoil && n == 2) begin
        w_we = 1'b1; w_row = 2'd0; w_col = 2'd0; w_data = 8'sd99;
        start = 1'b1; run_len = KW'(1);
      end else begin
        w_we = 1'b0; start = 1'b0;
      end
      if (adv_s) t++;
      drive_step(t, k_len);
      if (res_valid) begin
        for (int j = 0; j < N; j++) begin
          int exp = 0;
          int got;
          for (int i = 0; i < N; i++) exp += int'(xm[idx][i]) * int'(wm[i][j]);
          got = $signed(res_data[32*j +: 32]);
          chk(got == exp, "R2", {tag, " result column"}, got, exp);
        end
        idx++;
      end
      if (done) break;
      if (n > 500) break;
    end
    w_we = 1'b0; start = 1'b0;
    chk(n == b, "R5", {tag, " busy cycles to done"}, n, b);
    chk(steps == s, "R4", {tag, " advancing steps"}, steps, s);
    chk(idx == k_len, "R2", {tag, " result vector count"}, idx, k_len);
    chk(!busy, "R6", {tag, " busy low with done"}, busy, 0);
    chk(mac_cnt == CW'(N * N * k_len), "R7", {tag, " mac count"}, mac_cnt, N * N * k_len);
    chk(wall_cnt == CW'(s), "R8", {tag, " wall count"}, wall_cnt, s);
    @(negedge clk);
    chk(!done, "R6", {tag, " done single cycle"}, done, 0);
    chk(mac_cnt == CW'(N * N * k_len), "R7", {tag, " mac count held"}, mac_cnt, N * N * k_len);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(!busy && !done && !res_valid && !adv, "R10", "control outputs after reset",
        {busy, done, res_valid, adv}, 0);
    chk(mac_cnt == 0 && wall_cnt == 0, "R10", "counters after reset", mac_cnt + wall_cnt, 0);
  endtask

  task automatic t_basic;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) wm[i][j] = 8'(i * 3 - j * 2 + 1);
    for (int k = 0; k < 16; k++)
      for (int i = 0; i < N; i++) xm[k][i] = 8'(k * 5 - i * 7 + 2);
    load_all();
    run_k(5, 0, "basic K=5");
  endtask

  task automatic t_single;
    run_k(1, 0, "edge K=1");
  endtask

  task automatic t_extreme;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) wm[i][j] = ((i + j) % 2 == 0) ? -8'sd128 : 8'sd127;
    for (int k = 0; k < 16; k++)
      for (int i = 0; i < N; i++) xm[k][i] = ((k + i) % 3 == 0) ? -8'sd128 : 8'sd127;
    load_all();
    run_k(10, 0, "extremes K=10");
  endtask

  task automatic t_spoil;
    for (int k = 0; k < 16; k++)
      for (int i = 0; i < N; i++) xm[k][i] = 8'(k - 2 * i + 3);
    run_k(6, 1, "blocked write/restart R1 R9");
  endtask

  task automatic t_reload;
    @(negedge clk);
    wm[0][0] = -8'sd7;
    w_we = 1'b1; w_row = 2'd0; w_col = 2'd0; w_data = wm[0][0];
    @(posedge clk);
    @(negedge clk);
    w_we = 1'b0;
    run_k(2, 0, "idle reload R1");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_single();
    t_extreme();
    t_spoil();
    t_reload();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog run did not complete actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule